// File: doc/BRIEF.md
# Bit-Depth Adapter Control Register Block

This block is the host-facing register file of a streaming pixel bit-depth adapter. A host CPU reaches it through a 32-bit, word-aligned read/write port. Some registers report the adapter's build-time configuration. Some return the header fields decoded from the most recent image information packet. One reports the live status. Three are writable settings: the outgoing bits-per-color value, a dither bypass flag and a 30-bit random seed.

Writable settings are staged. A host write lands in a shadow copy and raises a pending flag. The live copy that drives the datapath does not change yet. A write to the commit register arms an update. The shadow values move into the live copy on the next field-start pulse, and the pending flag clears at the same time. Settings therefore never change in the middle of a field. The host writes the true bit count. The datapath receives that count minus one, which is the form used in outgoing packet headers.

Top module: `vid_bps_regmap`

## Requirements
- R1: A read of byte offset 0x000 returns 0x6AF7024C.
- R2: The read-only parameter words return build parameters: 0x004 version, 0x008 lite flag, 0x00C debug flag, 0x010 input bits per color, 0x014 output bits per color, 0x018 dither flag, 0x01C noise operation, 0x020/0x024/0x028/0x02C pad bits for channels 2/1/0/3, 0x030 fixed seed. The dither-only words 0x01C to 0x030 read 0 when dithering is not built.
- R3: A write to 0x148 (bits 4:0), 0x14C (bit 0) or 0x150 (bits 29:0) updates the shadow copy, which reads back at that offset. The write sets status bit 1 (pending) at 0x140.
- R4: Shadow values reach the live outputs, and pending clears, only at the edge where `fld_start` is high and a commit write to 0x144 was taken on an earlier edge. Without an armed commit, a field start changes nothing.
- R5: `live_bps_m1` equals the committed bits-per-color count minus one, modulo 32.
- R6: A commit write taken on the same edge as a field start takes effect at the following field start.
- R7: Status bit 0 equals `fld_busy` as sampled on the read request edge.
- R8: With the debug parameter set, 0x120 returns width field plus one and 0x124 returns height field plus one, both modulo 2^16. 0x128 returns interlace (4 bits), 0x130 color space (7), 0x134 subsampling (2), 0x138 cositing (2) and 0x13C field count (7), all zero-extended. With the debug parameter clear, these words read 0.
- R9: Reserved (0x12C), commit (0x144) and unmapped offsets read 0. Writes to read-only or unmapped offsets change no register and set no pending flag.
- R10: `live_bypass` carries committed config bit 0. `live_seed` carries the committed seed bits 29:0. Bits 31:30 of the seed write are dropped.
- R11: `host_rvalid` is high exactly one cycle after each `host_ren` cycle, with `host_rdata` valid in that cycle, and low otherwise.
- R12: Synchronous reset clears pending. It loads the shadow count with the input bits-per-color parameter and `live_bps_m1` with that value minus one, clears bypass, and loads the seed with the low 30 bits of the fixed seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | ADDR_W | Byte address; bits 1:0 ignored |
| host_wen | input | 1 | Write strobe |
| host_wdata | input | 32 | Write data |
| host_ren | input | 1 | Read strobe |
| host_rdata | output | 32 | Read data |
| host_rvalid | output | 1 | Read data valid |
| fld_start | input | 1 | Field boundary pulse |
| fld_busy | input | 1 | Datapath is processing a field |
| hdr_width_m1 | input | 16 | Header width minus one |
| hdr_height_m1 | input | 16 | Header height minus one |
| hdr_ilace | input | 4 | Header interlace code |
| hdr_csp | input | 7 | Header color space code |
| hdr_subs | input | 2 | Header subsampling code |
| hdr_cosite | input | 2 | Header cositing code |
| hdr_fcount | input | 7 | Header field count |
| live_bps_m1 | output | 5 | Committed bits per color minus one |
| live_bypass | output | 1 | Committed dither bypass |
| live_seed | output | 30 | Committed random seed |

## Verification
Read data is due one cycle after the request edge. Writes are visible to a read issued on the next edge. Live outputs change on the field-start edge itself. The bench drives every stimulus at a falling edge and queues the expected read word when it issues the read. A monitor pops and compares that word at the falling edge that follows the capture edge. Live outputs are compared at the falling edge right after each field-start pulse. A commit and a boundary on the same edge are driven together to show that the live outputs hold until the next boundary.

// File: rtl/vbr_pkg.sv
package vbr_pkg;

   localparam int BPS_FW  = 5;
   localparam int SEED_W  = 30;
   localparam logic [31:0] ID_WORD = 32'h6AF7_024C;

   // word indices (byte offset / 4)
   localparam logic [15:0] W_ID     = 16'h0000;
   localparam logic [15:0] W_VER    = 16'h0001;
   localparam logic [15:0] W_LITE   = 16'h0002;
   localparam logic [15:0] W_DBG    = 16'h0003;
   localparam logic [15:0] W_BPSI   = 16'h0004;
   localparam logic [15:0] W_BPSO   = 16'h0005;
   localparam logic [15:0] W_DEN    = 16'h0006;
   localparam logic [15:0] W_NOP    = 16'h0007;
   localparam logic [15:0] W_PAD2   = 16'h0008;
   localparam logic [15:0] W_PAD1   = 16'h0009;
   localparam logic [15:0] W_PAD0   = 16'h000A;
   localparam logic [15:0] W_PAD3   = 16'h000B;
   localparam logic [15:0] W_FSEED  = 16'h000C;
   localparam logic [15:0] W_HWID   = 16'h0048;
   localparam logic [15:0] W_HHGT   = 16'h0049;
   localparam logic [15:0] W_HILC   = 16'h004A;
   localparam logic [15:0] W_HCSP   = 16'h004C;
   localparam logic [15:0] W_HSUB   = 16'h004D;
   localparam logic [15:0] W_HCOS   = 16'h004E;
   localparam logic [15:0] W_HFCN   = 16'h004F;
   localparam logic [15:0] W_STAT   = 16'h0050;
   localparam logic [15:0] W_COMMIT = 16'h0051;
   localparam logic [15:0] W_SBPS   = 16'h0052;
   localparam logic [15:0] W_SCFG   = 16'h0053;
   localparam logic [15:0] W_SSEED  = 16'h0054;

   typedef struct packed {
      logic [15:0] wid;
      logic [15:0] hgt;
      logic [3:0]  ilace;
      logic [6:0]  csp;
      logic [1:0]  subs;
      logic [1:0]  cos;
      logic [6:0]  fcnt;
   } vbr_info_t;

   typedef struct packed {
      logic [BPS_FW-1:0] bps;
      logic              byp;
      logic [SEED_W-1:0] seed;
   } vbr_cfg_t;

endpackage

// File: rtl/vbr_host_dec.sv
module vbr_host_dec #(
   parameter int ADDR_W = 12
) (
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_wen,
   output logic [15:0]       widx,
   output logic              wr_bps,
   output logic              wr_cfg,
   output logic              wr_seed,
   output logic              wr_commit,
   output logic              wr_shadow
);
   import vbr_pkg::*;

   localparam int WIDX_W = ADDR_W - 2;

   logic [WIDX_W-1:0] word_sel;

   assign word_sel  = host_addr[ADDR_W-1:2];
   assign widx      = 16'(word_sel);
   assign wr_bps    = host_wen && (widx == W_SBPS);
   assign wr_cfg    = host_wen && (widx == W_SCFG);
   assign wr_seed   = host_wen && (widx == W_SSEED);
   assign wr_commit = host_wen && (widx == W_COMMIT);
   assign wr_shadow = wr_bps || wr_cfg || wr_seed;

endmodule

// File: rtl/vbr_stage.sv
module vbr_stage #(
   parameter int          BPS_IN     = 10,
   parameter logic [31:0] FIXED_SEED = 32'h0ABC_1234
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_bps,
   input  logic             wr_cfg,
   input  logic             wr_seed,
   input  logic             wr_commit,
   input  logic [31:0]      wdata,
   input  logic             fld_start,
   output vbr_pkg::vbr_cfg_t shadow_q,
   output vbr_pkg::vbr_cfg_t live_q,
   output logic             pending_q,
   output logic             armed_q
);
   import vbr_pkg::*;

   localparam logic [BPS_FW-1:0] BPS_RST    = BPS_FW'(BPS_IN);
   localparam logic [BPS_FW-1:0] BPS_RST_M1 = BPS_FW'(BPS_IN - 1);
   localparam logic [SEED_W-1:0] SEED_RST   = FIXED_SEED[SEED_W-1:0];

   logic apply;
   logic any_wr;

   assign apply  = fld_start && armed_q;
   assign any_wr = wr_bps || wr_cfg || wr_seed;

   always_ff @(posedge clk) begin
      if (rst) begin
         shadow_q.bps  <= BPS_RST;
         shadow_q.byp  <= 1'b0;
         shadow_q.seed <= SEED_RST;
      end else begin
         if (wr_bps)  shadow_q.bps  <= wdata[BPS_FW-1:0];
         if (wr_cfg)  shadow_q.byp  <= wdata[0];
         if (wr_seed) shadow_q.seed <= wdata[SEED_W-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         live_q.bps  <= BPS_RST_M1;
         live_q.byp  <= 1'b0;
         live_q.seed <= SEED_RST;
      end else if (apply) begin
         live_q.bps  <= shadow_q.bps - 1'b1;
         live_q.byp  <= shadow_q.byp;
         live_q.seed <= shadow_q.seed;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pending_q <= 1'b0;
         armed_q   <= 1'b0;
      end else begin
         if (any_wr)     pending_q <= 1'b1;
         else if (apply) pending_q <= 1'b0;
         if (wr_commit)  armed_q   <= 1'b1;
         else if (apply) armed_q   <= 1'b0;
      end
   end

endmodule

// File: rtl/vbr_info_rb.sv
module vbr_info_rb #(
   parameter bit DEBUG_EN = 1'b1
) (
   input  logic [15:0]       hdr_width_m1,
   input  logic [15:0]       hdr_height_m1,
   input  logic [3:0]        hdr_ilace,
   input  logic [6:0]        hdr_csp,
   input  logic [1:0]        hdr_subs,
   input  logic [1:0]        hdr_cosite,
   input  logic [6:0]        hdr_fcount,
   output vbr_pkg::vbr_info_t info
);
   generate
      if (DEBUG_EN) begin : g_dbg
         always_comb begin
            info.wid   = hdr_width_m1 + 16'd1;
            info.hgt   = hdr_height_m1 + 16'd1;
            info.ilace = hdr_ilace;
            info.csp   = hdr_csp;
            info.subs  = hdr_subs;
            info.cos   = hdr_cosite;
            info.fcnt  = hdr_fcount;
         end
      end else begin : g_nodbg
         assign info = '0;
      end
   endgenerate

endmodule

// File: rtl/vbr_rdmux.sv
module vbr_rdmux #(
   parameter logic [31:0] VERSION    = 32'h0104_0000,
   parameter bit          LITE       = 1'b0,
   parameter bit          DEBUG_EN   = 1'b1,
   parameter int          BPS_IN     = 10,
   parameter int          BPS_OUT    = 8,
   parameter bit          DITHER_EN  = 1'b1,
   parameter int          NOISE_OP   = 2,
   parameter int          PAD_CH2    = 2,
   parameter int          PAD_CH1    = 2,
   parameter int          PAD_CH0    = 2,
   parameter int          PAD_CH3    = 0,
   parameter logic [31:0] FIXED_SEED = 32'h0ABC_1234
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ren,
   input  logic [15:0]       widx,
   input  vbr_pkg::vbr_info_t info,
   input  vbr_pkg::vbr_cfg_t  shadow_q,
   input  logic              busy,
   input  logic              pending,
   output logic [31:0]       rdata,
   output logic              rvalid
);
   import vbr_pkg::*;

   localparam logic [31:0] P_LITE = 32'(LITE);
   localparam logic [31:0] P_DBG  = 32'(DEBUG_EN);
   localparam logic [31:0] P_BPSI = 32'(BPS_IN);
   localparam logic [31:0] P_BPSO = 32'(BPS_OUT);

   logic [31:0] p_den, p_nop, p_pad2, p_pad1, p_pad0, p_pad3, p_fseed;
   logic [31:0] nxt;

   generate
      if (DITHER_EN) begin : g_dith
         assign p_den   = 32'd1;
         assign p_nop   = 32'(NOISE_OP & 7);
         assign p_pad2  = 32'(PAD_CH2 & 15);
         assign p_pad1  = 32'(PAD_CH1 & 15);
         assign p_pad0  = 32'(PAD_CH0 & 15);
         assign p_pad3  = 32'(PAD_CH3 & 15);
         assign p_fseed = FIXED_SEED;
      end else begin : g_nodith
         assign p_den   = '0;
         assign p_nop   = '0;
         assign p_pad2  = '0;
         assign p_pad1  = '0;
         assign p_pad0  = '0;
         assign p_pad3  = '0;
         assign p_fseed = '0;
      end
   endgenerate

   always_comb begin
      nxt = '0;
      case (widx)
         W_ID:    nxt = ID_WORD;
         W_VER:   nxt = VERSION;
         W_LITE:  nxt = P_LITE;
         W_DBG:   nxt = P_DBG;
         W_BPSI:  nxt = P_BPSI;
         W_BPSO:  nxt = P_BPSO;
         W_DEN:   nxt = p_den;
         W_NOP:   nxt = p_nop;
         W_PAD2:  nxt = p_pad2;
         W_PAD1:  nxt = p_pad1;
         W_PAD0:  nxt = p_pad0;
         W_PAD3:  nxt = p_pad3;
         W_FSEED: nxt = p_fseed;
         W_HWID:  nxt = 32'(info.wid);
         W_HHGT:  nxt = 32'(info.hgt);
         W_HILC:  nxt = 32'(info.ilace);
         W_HCSP:  nxt = 32'(info.csp);
         W_HSUB:  nxt = 32'(info.subs);
         W_HCOS:  nxt = 32'(info.cos);
         W_HFCN:  nxt = 32'(info.fcnt);
         W_STAT:  nxt = {30'd0, pending, busy};
         W_SBPS:  nxt = 32'(shadow_q.bps);
         W_SCFG:  nxt = 32'(shadow_q.byp);
         W_SSEED: nxt = 32'(shadow_q.seed);
         default: nxt = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         rvalid <= ren;
         if (ren) rdata <= nxt;
      end
   end

endmodule

// File: rtl/vid_bps_regmap.sv
module vid_bps_regmap #(
   parameter int          ADDR_W     = 12,
   parameter logic [31:0] VERSION    = 32'h0104_0000,
   parameter bit          LITE       = 1'b0,
   parameter bit          DEBUG_EN   = 1'b1,
   parameter int          BPS_IN     = 10,
   parameter int          BPS_OUT    = 8,
   parameter bit          DITHER_EN  = 1'b1,
   parameter int          NOISE_OP   = 2,
   parameter int          PAD_CH2    = 2,
   parameter int          PAD_CH1    = 2,
   parameter int          PAD_CH0    = 2,
   parameter int          PAD_CH3    = 0,
   parameter logic [31:0] FIXED_SEED = 32'h0ABC_1234
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              host_wen,
   input  logic [31:0]       host_wdata,
   input  logic              host_ren,
   output logic [31:0]       host_rdata,
   output logic              host_rvalid,
   input  logic              fld_start,
   input  logic              fld_busy,
   input  logic [15:0]       hdr_width_m1,
   input  logic [15:0]       hdr_height_m1,
   input  logic [3:0]        hdr_ilace,
   input  logic [6:0]        hdr_csp,
   input  logic [1:0]        hdr_subs,
   input  logic [1:0]        hdr_cosite,
   input  logic [6:0]        hdr_fcount,
   output logic [4:0]        live_bps_m1,
   output logic              live_bypass,
   output logic [29:0]       live_seed
);
   import vbr_pkg::*;

   generate
      if (ADDR_W < 10 || ADDR_W > 18) begin : g_bad_addr
         $error("vid_bps_regmap: ADDR_W must be 10..18");
      end
      if (BPS_IN < 1 || BPS_IN > 31 || BPS_OUT < 1 || BPS_OUT > 31) begin : g_bad_bps
         $error("vid_bps_regmap: bits per color out of range");
      end
      if (NOISE_OP < 0 || NOISE_OP > 7) begin : g_bad_nop
         $error("vid_bps_regmap: noise operation is 3 bits");
      end
      if (PAD_CH0 > 15 || PAD_CH1 > 15 || PAD_CH2 > 15 || PAD_CH3 > 15 ||
          PAD_CH0 < 0 || PAD_CH1 < 0 || PAD_CH2 < 0 || PAD_CH3 < 0) begin : g_bad_pad
         $error("vid_bps_regmap: pad counts are 4 bits");
      end
   endgenerate

   logic [15:0] widx;
   logic        wr_bps, wr_cfg, wr_seed, wr_commit, wr_shadow;
   logic        st_pending, st_armed;
   vbr_cfg_t    shadow_q, live_q;
   vbr_info_t   info;

   vbr_host_dec #(.ADDR_W(ADDR_W)) u_dec (
      .host_addr (host_addr),
      .host_wen  (host_wen),
      .widx      (widx),
      .wr_bps    (wr_bps),
      .wr_cfg    (wr_cfg),
      .wr_seed   (wr_seed),
      .wr_commit (wr_commit),
      .wr_shadow (wr_shadow)
   );

   vbr_stage #(.BPS_IN(BPS_IN), .FIXED_SEED(FIXED_SEED)) u_stage (
      .clk       (clk),
      .rst       (rst),
      .wr_bps    (wr_bps),
      .wr_cfg    (wr_cfg),
      .wr_seed   (wr_seed),
      .wr_commit (wr_commit),
      .wdata     (host_wdata),
      .fld_start (fld_start),
      .shadow_q  (shadow_q),
      .live_q    (live_q),
      .pending_q (st_pending),
      .armed_q   (st_armed)
   );

   vbr_info_rb #(.DEBUG_EN(DEBUG_EN)) u_info (
      .hdr_width_m1  (hdr_width_m1),
      .hdr_height_m1 (hdr_height_m1),
      .hdr_ilace     (hdr_ilace),
      .hdr_csp       (hdr_csp),
      .hdr_subs      (hdr_subs),
      .hdr_cosite    (hdr_cosite),
      .hdr_fcount    (hdr_fcount),
      .info          (info)
   );

   vbr_rdmux #(
      .VERSION(VERSION), .LITE(LITE), .DEBUG_EN(DEBUG_EN),
      .BPS_IN(BPS_IN), .BPS_OUT(BPS_OUT), .DITHER_EN(DITHER_EN),
      .NOISE_OP(NOISE_OP), .PAD_CH2(PAD_CH2), .PAD_CH1(PAD_CH1),
      .PAD_CH0(PAD_CH0), .PAD_CH3(PAD_CH3), .FIXED_SEED(FIXED_SEED)
   ) u_rd (
      .clk      (clk),
      .rst      (rst),
      .ren      (host_ren),
      .widx     (widx),
      .info     (info),
      .shadow_q (shadow_q),
      .busy     (fld_busy),
      .pending  (st_pending),
      .rdata    (host_rdata),
      .rvalid   (host_rvalid)
   );

   assign live_bps_m1 = live_q.bps;
   assign live_bypass = live_q.byp;
   assign live_seed   = live_q.seed;

endmodule

// File: rtl/vbr_regmap_chk.sv
module vbr_regmap_chk #(
   parameter int ADDR_W = 12
) (
   input logic              clk,
   input logic              rst,
   input logic [ADDR_W-1:0] host_addr,
   input logic              host_ren,
   input logic [31:0]       host_rdata,
   input logic              host_rvalid,
   input logic              fld_start,
   input logic              wr_shadow,
   input logic              st_pending,
   input logic              st_armed,
   input logic [4:0]        live_bps_m1,
   input logic              live_bypass,
   input logic [29:0]       live_seed
);
   logic id_hit;
   assign id_hit = (host_addr[ADDR_W-1:2] == '0);

   // R11
   rvalid_after_read_chk: assert property (@(posedge clk) disable iff (rst)
      (host_ren && !rst) |=> host_rvalid);

   // R11
   rvalid_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (!host_ren) |=> !host_rvalid);

   // R1
   id_word_chk: assert property (@(posedge clk) disable iff (rst)
      (host_ren && id_hit && !rst) |=> (host_rdata == 32'h6AF7_024C));

   // R4
   live_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!fld_start && !rst) |=> ($stable(live_bps_m1) && $stable(live_bypass) && $stable(live_seed)));

   // R6
   unarmed_boundary_chk: assert property (@(posedge clk) disable iff (rst)
      (fld_start && !st_armed && !rst) |=> ($stable(live_bps_m1) && $stable(live_bypass) && $stable(live_seed)));

   // R3
   pending_set_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_shadow && !rst) |=> st_pending);

   // R4
   pending_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (fld_start && st_armed && !wr_shadow && !rst) |=> !st_pending);

endmodule

bind vid_bps_regmap vbr_regmap_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .host_addr   (host_addr),
   .host_ren    (host_ren),
   .host_rdata  (host_rdata),
   .host_rvalid (host_rvalid),
   .fld_start   (fld_start),
   .wr_shadow   (wr_shadow),
   .st_pending  (st_pending),
   .st_armed    (st_armed),
   .live_bps_m1 (live_bps_m1),
   .live_bypass (live_bypass),
   .live_seed   (live_seed)
);

// File: tb/tb_vid_bps_regmap.sv
`timescale 1ns/1ps
module tb_vid_bps_regmap;
   localparam int          ADDR_W = 12;
   localparam logic [31:0] SEED   = 32'h0ABC_1234;
   localparam logic [31:0] VER    = 32'h0104_0000;

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [ADDR_W-1:0] host_addr = '0;
   logic              host_wen = 1'b0;
   logic [31:0]       host_wdata = '0;
   logic              host_ren = 1'b0;
   logic [31:0]       host_rdata;
   logic              host_rvalid;
   logic              fld_start = 1'b0;
   logic              fld_busy = 1'b0;
   logic [15:0]       hdr_width_m1 = '0;
   logic [15:0]       hdr_height_m1 = '0;
   logic [3:0]        hdr_ilace = '0;
   logic [6:0]        hdr_csp = '0;
   logic [1:0]        hdr_subs = '0;
   logic [1:0]        hdr_cosite = '0;
   logic [6:0]        hdr_fcount = '0;
   logic [4:0]        live_bps_m1;
   logic              live_bypass;
   logic [29:0]       live_seed;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];
   logic [31:0] adr_q[$];

   always #2 clk = ~clk;

   vid_bps_regmap #(.ADDR_W(ADDR_W), .FIXED_SEED(SEED), .VERSION(VER)) dut (
      .clk(clk), .rst(rst), .host_addr(host_addr), .host_wen(host_wen),
      .host_wdata(host_wdata), .host_ren(host_ren), .host_rdata(host_rdata),
      .host_rvalid(host_rvalid), .fld_start(fld_start), .fld_busy(fld_busy),
      .hdr_width_m1(hdr_width_m1), .hdr_height_m1(hdr_height_m1),
      .hdr_ilace(hdr_ilace), .hdr_csp(hdr_csp), .hdr_subs(hdr_subs),
      .hdr_cosite(hdr_cosite), .hdr_fcount(hdr_fcount),
      .live_bps_m1(live_bps_m1), .live_bypass(live_bypass), .live_seed(live_seed)
   );

   // monitor: pops one expected word per returned read
   always @(negedge clk) begin
      if (!rst && host_rvalid) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R11: unexpected rvalid, got %h exp none", host_rdata);
         end else begin
            logic [31:0] e;
            logic [31:0] a;
            string t;
            e = exp_q.pop_front();
            a = adr_q.pop_front();
            t = tag_q.pop_front();
            if (host_rdata !== e) begin
               errors++;
               $display("FAIL %s: read %h got %h exp %h", t, a, host_rdata, e);
            end
         end
      end
   end

   task automatic host_write(input logic [31:0] a, input logic [31:0] d);
      host_addr  = a[ADDR_W-1:0];
      host_wdata = d;
      host_wen   = 1'b1;
      @(negedge clk);
      host_wen   = 1'b0;
   endtask

   task automatic host_read(input logic [31:0] a, input logic [31:0] e, input string t);
      host_addr = a[ADDR_W-1:0];
      host_ren  = 1'b1;
      exp_q.push_back(e);
      adr_q.push_back(a);
      tag_q.push_back(t);
      @(negedge clk);
      host_ren  = 1'b0;
   endtask

   task automatic field_pulse();
      fld_start = 1'b1;
      @(negedge clk);
      fld_start = 1'b0;
   endtask

   task automatic check_live(input logic [4:0] b, input logic y, input logic [29:0] s, input string t);
      checks++;
      if (live_bps_m1 !== b || live_bypass !== y || live_seed !== s) begin
         errors++;
         $display("FAIL %s: live got %h/%b/%h exp %h/%b/%h", t,
                  live_bps_m1, live_bypass, live_seed, b, y, s);
      end
   endtask

   task automatic check_bit(input logic got, input logic e, input string t);
      checks++;
      if (got !== e) begin
         errors++;
         $display("FAIL %s: got %b exp %b", t, got, e);
      end
   endtask

   task automatic drain();
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R12 reset state
      check_live(5'd9, 1'b0, SEED[29:0], "R12");
      check_bit(host_rvalid, 1'b0, "R11");
      host_read(32'h140, 32'h0, "R12");
      host_read(32'h148, 32'd10, "R12");
      // R1 / R2 identity and parameters
      host_read(32'h000, 32'h6AF7_024C, "R1");
      host_read(32'h004, VER, "R2");
      host_read(32'h008, 32'd0, "R2");
      host_read(32'h00C, 32'd1, "R2");
      host_read(32'h010, 32'd10, "R2");
      host_read(32'h014, 32'd8, "R2");
      host_read(32'h018, 32'd1, "R2");
      host_read(32'h01C, 32'd2, "R2");
      host_read(32'h020, 32'd2, "R2");
      host_read(32'h024, 32'd2, "R2");
      host_read(32'h028, 32'd2, "R2");
      host_read(32'h02C, 32'd0, "R2");
      host_read(32'h030, SEED, "R2");
      drain();
      check_bit(host_rvalid, 1'b0, "R11");
      // R3 shadow write sets pending
      host_write(32'h148, 32'd8);
      host_read(32'h140, 32'h2, "R3");
      host_read(32'h148, 32'd8, "R3");
      // R4 boundary without commit changes nothing
      field_pulse();
      check_live(5'd9, 1'b0, SEED[29:0], "R4");
      host_read(32'h140, 32'h2, "R4");
      // R6 commit on the boundary edge waits for the next one
      host_addr  = 12'h144;
      host_wdata = 32'hDEAD_BEEF;
      host_wen   = 1'b1;
      fld_start  = 1'b1;
      @(negedge clk);
      host_wen   = 1'b0;
      fld_start  = 1'b0;
      check_live(5'd9, 1'b0, SEED[29:0], "R6");
      field_pulse();
      check_live(5'd7, 1'b0, SEED[29:0], "R5");
      host_read(32'h140, 32'h0, "R4");
      // R10 bypass and seed masking
      host_write(32'h14C, 32'hFFFF_FFFF);
      host_write(32'h150, 32'hFFFF_FFFF);
      host_write(32'h148, 32'd16);
      host_read(32'h14C, 32'd1, "R10");
      host_read(32'h150, 32'h3FFF_FFFF, "R10");
      host_write(32'h144, 32'd0);
      check_live(5'd7, 1'b0, SEED[29:0], "R4");
      field_pulse();
      check_live(5'd15, 1'b1, 30'h3FFF_FFFF, "R10");
      // R5 zero count wraps
      host_write(32'h148, 32'd0);
      host_write(32'h144, 32'd0);
      field_pulse();
      check_live(5'd31, 1'b1, 30'h3FFF_FFFF, "R5");
      // R7 busy mirror
      fld_busy = 1'b1;
      host_read(32'h140, 32'h1, "R7");
      fld_busy = 1'b0;
      host_read(32'h140, 32'h0, "R7");
      // R8 header readback
      hdr_width_m1  = 16'd1919;
      hdr_height_m1 = 16'd1079;
      hdr_ilace     = 4'hA;
      hdr_csp       = 7'h55;
      hdr_subs      = 2'd2;
      hdr_cosite    = 2'd1;
      hdr_fcount    = 7'h7F;
      host_read(32'h120, 32'd1920, "R8");
      host_read(32'h124, 32'd1080, "R8");
      host_read(32'h128, 32'hA, "R8");
      host_read(32'h130, 32'h55, "R8");
      host_read(32'h134, 32'd2, "R8");
      host_read(32'h138, 32'd1, "R8");
      host_read(32'h13C, 32'h7F, "R8");
      hdr_width_m1  = 16'hFFFF;
      host_read(32'h120, 32'd0, "R8");
      // R9 reserved, unmapped and read-only
      host_write(32'h000, 32'h0);
      host_write(32'h010, 32'h0);
      host_write(32'h200, 32'hFFFF_FFFF);
      host_write(32'h12C, 32'h5);
      host_read(32'h000, 32'h6AF7_024C, "R9");
      host_read(32'h010, 32'd10, "R9");
      host_read(32'h200, 32'h0, "R9");
      host_read(32'h12C, 32'h0, "R9");
      host_read(32'h144, 32'h0, "R9");
      host_read(32'h140, 32'h0, "R9");
      field_pulse();
      check_live(5'd31, 1'b1, 30'h3FFF_FFFF, "R9");
      drain();
      if (exp_q.size() != 0) begin
         checks++;
         errors++;
         $display("FAIL R11: %0d reads got no data, got 0 exp %0d", exp_q.size(), exp_q.size());
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule